// File: doc/BRIEF.md
# Explicit Macro-Op Issue Unit

An in-order issue unit for a small register machine. Parallel issue comes from software, not from dynamic grouping. A program opens a definition with a begin marker, lists a few operations and closes it with an end marker. Those operations are stored in a macro slot and do not execute while they are being recorded. A later call to the slot executes every stored operation in one clock cycle. All sources are read before any destination is written, so the operations behave as one parallel bundle.

A compare-increment-branch instruction can target a macro slot instead of an address. In each cycle it executes the slot's operations and increments a counter register. It repeats, one iteration per cycle, while the incremented counter is still below a limit register. The number of slots is kept small because a context switch must save and restore their contents. A dedicated port provides that save and restore. A clear instruction empties a slot. The issue unit stalls while any register an instruction would read is marked busy by the surrounding machine.

Top module: `mop_issue_unit`

## Requirements
- R1: After reset all registers read zero, every slot entry is invalid, no definition is open, both error flags are low and `in_ready` is high.
- R2: Single operations execute in the cycle they are accepted, with opcodes ADD=1 (rd=rs1+rs2), SUB=2 (rd=rs1-rs2), AND=3, XOR=4 and MOVI=5 (rd=imm). Results wrap modulo 2^DATA_W. Opcode 0 and other unlisted codes do nothing.
- R3: BEGIN (opcode 8, slot in `imm[0]`) empties the slot and opens a definition. Until END (opcode 9), every accepted instruction is stored and not executed, including while registers are busy, and `in_ready` stays high.
- R4: A definition keeps at most OPS entries. An instruction recorded into a full slot is discarded, and `err_ovf_o` is high for the cycle after it is accepted.
- R5: CALL (opcode 10, slot in `imm[0]`) executes all valid entries of the slot in one accepted cycle. Every entry reads the register values from before that cycle. Stored entries that are not ADD/SUB/AND/XOR/MOVI do nothing.
- R6: When two writers in one cycle target the same register, `err_dup_o` is high for the next cycle. The higher entry index wins, and the loop counter increment wins over every entry.
- R7: LOOP (opcode 12, counter `rd`, limit `rs1`, slot in `imm[0]`) executes the slot and sets the counter to counter+1 in the same cycle. It repeats every cycle, with `in_ready` low, while counter+1 < limit, compared unsigned without wrap. The instruction is consumed on the first cycle where this does not hold.
- R8: CLEAR (opcode 11, slot in `imm[0]`) invalidates every entry of the slot. A CALL of an empty slot changes no register and raises no error.
- R9: While any source register of the presented instruction (including all sources of a called macro, and the counter and limit of LOOP) has its `reg_busy` bit set, `in_ready` is low and no register changes.
- R10: The save/restore port reads entry `sv_idx` of slot `sv_slot` combinationally, as valid bit and entry. The entry is packed MSB to LSB as {op[3:0], rd, rs1, rs2, imm}. A write with `sv_we` stores the entry and its valid bit at the next edge. Recording appends at the index equal to the slot's count of valid entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction presented |
| in_ready | output | 1 | Instruction accepted at this edge |
| in_op | input | 4 | Opcode |
| in_rd | input | $clog2(NREG) | Destination or loop counter register |
| in_rs1 | input | $clog2(NREG) | First source or loop limit register |
| in_rs2 | input | $clog2(NREG) | Second source register |
| in_imm | input | DATA_W | Immediate or slot number |
| reg_busy | input | NREG | Per-register operand-not-ready flags |
| regs_o | output | NREG*DATA_W | Register file contents, register r at bits r*DATA_W |
| defining_o | output | 1 | A macro definition is open |
| err_dup_o | output | 1 | Previous execution had two writers for one register |
| err_ovf_o | output | 1 | Previous recorded instruction was discarded |
| sv_slot | input | $clog2(SLOTS) | Save/restore slot select |
| sv_idx | input | $clog2(OPS) | Save/restore entry select |
| sv_we | input | 1 | Restore write enable |
| sv_wvalid | input | 1 | Valid bit to restore |
| sv_wentry | input | 4+3*$clog2(NREG)+DATA_W | Entry to restore |
| sv_rvalid | output | 1 | Valid bit of the selected entry |
| sv_rentry | output | 4+3*$clog2(NREG)+DATA_W | Selected entry |

## Verification
The checker watches four things on every cycle. A stalled or recorded instruction must leave the register file untouched. The unit must stay ready while a definition is open. A busy source must hold `in_ready` low. Each non-stalled LOOP cycle must advance its counter by exactly one. Only the bench's scenarios can show the actual results. These include the arithmetic of every ALU opcode over a sweep of operand pairs, the read-before-write order inside a macro, and which writer wins a conflict. They also include the exact iteration count of a loop at and below its limit, the overflow discard, and a restored slot executing what was written.

// File: rtl/mop_pkg.sv
package mop_pkg;
   localparam int OP_W = 4;

   typedef enum logic [OP_W-1:0] {
      OP_NOP   = 4'd0,
      OP_ADD   = 4'd1,
      OP_SUB   = 4'd2,
      OP_AND   = 4'd3,
      OP_XOR   = 4'd4,
      OP_MOVI  = 4'd5,
      OP_BEGIN = 4'd8,
      OP_END   = 4'd9,
      OP_CALL  = 4'd10,
      OP_CLEAR = 4'd11,
      OP_LOOP  = 4'd12
   } op_e;

   function automatic logic op_is_alu(logic [OP_W-1:0] op);
      return (op == OP_ADD) || (op == OP_SUB) || (op == OP_AND) ||
             (op == OP_XOR) || (op == OP_MOVI);
   endfunction

   function automatic logic op_reads_regs(logic [OP_W-1:0] op);
      return (op == OP_ADD) || (op == OP_SUB) || (op == OP_AND) || (op == OP_XOR);
   endfunction
endpackage

// File: rtl/mop_regfile.sv
module mop_regfile #(
   parameter int NREG   = 4,
   parameter int DATA_W = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   we,
   input  logic [NREG*DATA_W-1:0] nxt,
   output logic [NREG*DATA_W-1:0] q
);
   for (genvar r = 0; r < NREG; r++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n)  q[r*DATA_W +: DATA_W] <= '0;
         else if (we) q[r*DATA_W +: DATA_W] <= nxt[r*DATA_W +: DATA_W];
      end
   end
endmodule

// File: rtl/mop_macro_store.sv
module mop_macro_store #(
   parameter int SLOTS = 2,
   parameter int OPS   = 4,
   parameter int EW    = 18,
   localparam int SAW  = $clog2(SLOTS),
   localparam int OAW  = $clog2(OPS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_en,
   input  logic [SAW-1:0]    clr_slot,
   input  logic              app_en,
   input  logic [SAW-1:0]    app_slot,
   input  logic [EW-1:0]     app_entry,
   output logic              app_full,
   input  logic [SAW-1:0]    ex_slot,
   output logic [OPS*EW-1:0] ex_ent,
   output logic [OPS-1:0]    ex_vld,
   input  logic [SAW-1:0]    sv_slot,
   input  logic [OAW-1:0]    sv_idx,
   input  logic              sv_we,
   input  logic              sv_wvalid,
   input  logic [EW-1:0]     sv_wentry,
   output logic              sv_rvalid,
   output logic [EW-1:0]     sv_rentry
);
   logic [EW-1:0]  ent_q [SLOTS][OPS];
   logic [OPS-1:0] vld_q [SLOTS];
   logic [OAW:0]   app_cnt;
   logic [OAW-1:0] app_idx;

   assign app_cnt  = (OAW+1)'($countones(vld_q[app_slot]));
   assign app_full = (app_cnt == (OAW+1)'(OPS));
   assign app_idx  = app_cnt[OAW-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SLOTS; s++) begin
            vld_q[s] <= '0;
            for (int i = 0; i < OPS; i++) ent_q[s][i] <= '0;
         end
      end else begin
         if (clr_en) vld_q[clr_slot] <= '0;
         if (app_en) begin
            ent_q[app_slot][app_idx] <= app_entry;
            vld_q[app_slot][app_idx] <= 1'b1;
         end
         if (sv_we) begin
            ent_q[sv_slot][sv_idx] <= sv_wentry;
            vld_q[sv_slot][sv_idx] <= sv_wvalid;
         end
      end
   end

   for (genvar i = 0; i < OPS; i++) begin : g_rd
      assign ex_ent[i*EW +: EW] = ent_q[ex_slot][i];
   end
   assign ex_vld    = vld_q[ex_slot];
   assign sv_rvalid = vld_q[sv_slot][sv_idx];
   assign sv_rentry = ent_q[sv_slot][sv_idx];
endmodule

// File: rtl/mop_exec.sv
module mop_exec import mop_pkg::*; #(
   parameter int DATA_W = 8,
   parameter int NREG   = 4,
   parameter int OPS    = 4,
   localparam int RAW   = $clog2(NREG),
   localparam int EW    = OP_W + 3*RAW + DATA_W
) (
   input  logic [NREG*DATA_W-1:0] regs_i,
   input  logic [OPS*EW-1:0]      lane_ent,
   input  logic [OPS-1:0]         lane_vld,
   input  logic                   inc_en,
   input  logic [RAW-1:0]         inc_idx,
   output logic [NREG*DATA_W-1:0] regs_nxt,
   output logic [NREG-1:0]        src_mask,
   output logic                   dup
);
   logic [DATA_W-1:0] lane_res [OPS];
   logic [NREG-1:0]   lane_w   [OPS];
   logic [NREG-1:0]   lane_src [OPS];
   logic [DATA_W-1:0] inc_val;

   for (genvar i = 0; i < OPS; i++) begin : g_lane
      logic [OP_W-1:0]   op;
      logic [RAW-1:0]    rd, rs1, rs2;
      logic [DATA_W-1:0] imm, a, b, res;

      assign {op, rd, rs1, rs2, imm} = lane_ent[i*EW +: EW];
      assign a = regs_i[rs1*DATA_W +: DATA_W];
      assign b = regs_i[rs2*DATA_W +: DATA_W];

      always_comb begin
         case (op)
            OP_ADD:  res = a + b;
            OP_SUB:  res = a - b;
            OP_AND:  res = a & b;
            OP_XOR:  res = a ^ b;
            OP_MOVI: res = imm;
            default: res = '0;
         endcase
      end

      assign lane_res[i] = res;
      assign lane_w[i]   = (lane_vld[i] && op_is_alu(op)) ? (NREG'(1) << rd) : '0;
      assign lane_src[i] = (lane_vld[i] && op_reads_regs(op)) ?
                           ((NREG'(1) << rs1) | (NREG'(1) << rs2)) : '0;
   end

   assign inc_val = regs_i[inc_idx*DATA_W +: DATA_W] + 1'b1;

   always_comb begin
      regs_nxt = regs_i;
      dup      = 1'b0;
      src_mask = inc_en ? (NREG'(1) << inc_idx) : '0;
      for (int i = 0; i < OPS; i++) src_mask = src_mask | lane_src[i];
      for (int r = 0; r < NREG; r++) begin
         int n;
         n = 0;
         for (int i = 0; i < OPS; i++) begin
            if (lane_w[i][r]) begin
               regs_nxt[r*DATA_W +: DATA_W] = lane_res[i];
               n = n + 1;
            end
         end
         if (inc_en && (inc_idx == RAW'(r))) begin
            regs_nxt[r*DATA_W +: DATA_W] = inc_val;
            n = n + 1;
         end
         if (n > 1) dup = 1'b1;
      end
   end
endmodule

// File: rtl/mop_issue_unit.sv
module mop_issue_unit import mop_pkg::*; #(
   parameter int DATA_W = 8,
   parameter int NREG   = 4,
   parameter int SLOTS  = 2,
   parameter int OPS    = 4,
   localparam int RAW   = $clog2(NREG),
   localparam int SAW   = $clog2(SLOTS),
   localparam int OAW   = $clog2(OPS),
   localparam int EW    = OP_W + 3*RAW + DATA_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   output logic                   in_ready,
   input  logic [OP_W-1:0]        in_op,
   input  logic [RAW-1:0]         in_rd,
   input  logic [RAW-1:0]         in_rs1,
   input  logic [RAW-1:0]         in_rs2,
   input  logic [DATA_W-1:0]      in_imm,
   input  logic [NREG-1:0]        reg_busy,
   output logic [NREG*DATA_W-1:0] regs_o,
   output logic                   defining_o,
   output logic                   err_dup_o,
   output logic                   err_ovf_o,
   input  logic [SAW-1:0]         sv_slot,
   input  logic [OAW-1:0]         sv_idx,
   input  logic                   sv_we,
   input  logic                   sv_wvalid,
   input  logic [EW-1:0]          sv_wentry,
   output logic                   sv_rvalid,
   output logic [EW-1:0]          sv_rentry
);
   if (NREG < 2 || (NREG & (NREG-1)) != 0) begin : g_bad_nreg
      $error("NREG must be a power of two of at least 2");
   end
   if (SLOTS < 2 || (SLOTS & (SLOTS-1)) != 0) begin : g_bad_slots
      $error("SLOTS must be a power of two of at least 2");
   end
   if (OPS < 2 || (OPS & (OPS-1)) != 0) begin : g_bad_ops
      $error("OPS must be a power of two of at least 2");
   end
   if (DATA_W < SAW) begin : g_bad_dw
      $error("DATA_W too narrow to carry a slot number");
   end

   logic                   def_q;
   logic [SAW-1:0]         def_slot_q;
   logic                   err_dup_q, err_ovf_q;
   logic [EW-1:0]          in_ent;
   logic [SAW-1:0]         tgt_slot;
   logic                   is_single, is_call, is_loop, is_begin, is_clear, is_end;
   logic                   rec, app_full, accept, fire, stall, rpt;
   logic [OPS*EW-1:0]      slot_ent, lane_ent;
   logic [OPS-1:0]         slot_vld, lane_vld;
   logic [NREG*DATA_W-1:0] regs_q, regs_nxt;
   logic [NREG-1:0]        ex_src, src_all;
   logic                   dup;
   logic [DATA_W:0]        cnt_next, lim;

   assign in_ent   = {in_op, in_rd, in_rs1, in_rs2, in_imm};
   assign tgt_slot = in_imm[SAW-1:0];
   assign is_end    = (in_op == OP_END);
   assign is_single = !def_q && op_is_alu(in_op);
   assign is_call   = !def_q && (in_op == OP_CALL);
   assign is_loop   = !def_q && (in_op == OP_LOOP);
   assign is_begin  = !def_q && (in_op == OP_BEGIN);
   assign is_clear  = !def_q && (in_op == OP_CLEAR);
   assign rec       = in_valid && def_q && !is_end;

   always_comb begin
      lane_ent = slot_ent;
      lane_vld = slot_vld;
      if (is_single) begin
         lane_ent          = '0;
         lane_ent[EW-1:0]  = in_ent;
         lane_vld          = OPS'(1);
      end else if (!(is_call || is_loop)) begin
         lane_vld = '0;
      end
   end

   mop_macro_store #(.SLOTS(SLOTS), .OPS(OPS), .EW(EW)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_en    (accept && (is_begin || is_clear)),
      .clr_slot  (tgt_slot),
      .app_en    (rec && !app_full),
      .app_slot  (def_slot_q),
      .app_entry (in_ent),
      .app_full  (app_full),
      .ex_slot   (tgt_slot),
      .ex_ent    (slot_ent),
      .ex_vld    (slot_vld),
      .sv_slot   (sv_slot),
      .sv_idx    (sv_idx),
      .sv_we     (sv_we),
      .sv_wvalid (sv_wvalid),
      .sv_wentry (sv_wentry),
      .sv_rvalid (sv_rvalid),
      .sv_rentry (sv_rentry)
   );

   mop_exec #(.DATA_W(DATA_W), .NREG(NREG), .OPS(OPS)) u_exec (
      .regs_i   (regs_q),
      .lane_ent (lane_ent),
      .lane_vld (lane_vld),
      .inc_en   (is_loop),
      .inc_idx  (in_rd),
      .regs_nxt (regs_nxt),
      .src_mask (ex_src),
      .dup      (dup)
   );

   assign src_all  = ex_src | (is_loop ? (NREG'(1) << in_rs1) : '0);
   assign stall    = in_valid && |(src_all & reg_busy);
   assign cnt_next = {1'b0, regs_q[in_rd*DATA_W +: DATA_W]} + 1'b1;
   assign lim      = {1'b0, regs_q[in_rs1*DATA_W +: DATA_W]};
   assign rpt      = in_valid && is_loop && (cnt_next < lim);
   assign in_ready = !stall && !rpt;
   assign accept   = in_valid && in_ready;
   assign fire     = in_valid && !stall && (is_single || is_call || is_loop);

   mop_regfile #(.NREG(NREG), .DATA_W(DATA_W)) u_rf (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (fire),
      .nxt   (regs_nxt),
      .q     (regs_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         def_q      <= 1'b0;
         def_slot_q <= '0;
         err_dup_q  <= 1'b0;
         err_ovf_q  <= 1'b0;
      end else begin
         err_dup_q <= fire && dup;
         err_ovf_q <= rec && app_full;
         if (accept && is_begin) begin
            def_q      <= 1'b1;
            def_slot_q <= tgt_slot;
         end else if (accept && def_q && is_end) begin
            def_q <= 1'b0;
         end
      end
   end

   assign regs_o     = regs_q;
   assign defining_o = def_q;
   assign err_dup_o  = err_dup_q;
   assign err_ovf_o  = err_ovf_q;
endmodule

// File: rtl/mop_issue_checker.sv
module mop_issue_checker import mop_pkg::*; #(
   parameter int DATA_W = 8,
   parameter int NREG   = 4,
   localparam int RAW   = $clog2(NREG)
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   in_valid,
   input logic                   in_ready,
   input logic [OP_W-1:0]        in_op,
   input logic [RAW-1:0]         in_rd,
   input logic [NREG*DATA_W-1:0] regs_o,
   input logic                   defining_o,
   input logic                   stall
);
   logic [DATA_W-1:0] cur_rd_val;
   assign cur_rd_val = regs_o[in_rd*DATA_W +: DATA_W];

   // R9: a stalled instruction changes no register
   p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> $stable(regs_o));

   // R9: a busy source holds the handshake low
   p_busy_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> !in_ready);

   // R3: recorded instructions do not execute
   p_record_no_exec_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (defining_o && in_valid && in_op != OP_END) |=> $stable(regs_o));

   // R3: recording never stalls
   p_define_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
      defining_o |-> in_ready);

   // R7: every executing loop cycle advances its counter by one
   p_loop_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !defining_o && in_op == OP_LOOP && !stall) |=>
      (regs_o[$past(in_rd)*DATA_W +: DATA_W] == DATA_W'($past(cur_rd_val) + 1'b1)));
endmodule

bind mop_issue_unit mop_issue_checker #(.DATA_W(DATA_W), .NREG(NREG)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_ready   (in_ready),
   .in_op      (in_op),
   .in_rd      (in_rd),
   .regs_o     (regs_o),
   .defining_o (defining_o),
   .stall      (stall)
);

// File: tb/mop_issue_unit_test.sv
module mop_issue_unit_test;
   timeunit 1ns;
   timeprecision 1ps;
   import mop_pkg::*;

   localparam int D   = 8;
   localparam int NR  = 4;
   localparam int NS  = 2;
   localparam int NO  = 4;
   localparam int RAW = 2;
   localparam int SAW = 1;
   localparam int OAW = 2;
   localparam int EW  = 4 + 3*RAW + D;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic            rst_n, in_valid, in_ready;
   logic [3:0]      in_op;
   logic [RAW-1:0]  in_rd, in_rs1, in_rs2;
   logic [D-1:0]    in_imm;
   logic [NR-1:0]   reg_busy;
   logic [NR*D-1:0] regs_o;
   logic            defining_o, err_dup_o, err_ovf_o;
   logic [SAW-1:0]  sv_slot;
   logic [OAW-1:0]  sv_idx;
   logic            sv_we, sv_wvalid, sv_rvalid;
   logic [EW-1:0]   sv_wentry, sv_rentry;

   mop_issue_unit #(.DATA_W(D), .NREG(NR), .SLOTS(NS), .OPS(NO)) uut (.*);

   int checks = 0;
   int fails  = 0;

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [D-1:0] rv(int r);
      return regs_o[r*D +: D];
   endfunction

   function automatic logic [EW-1:0] ent(logic [3:0] op, int rd, int rs1, int rs2, logic [D-1:0] imm);
      return {op, RAW'(rd), RAW'(rs1), RAW'(rs2), imm};
   endfunction

   task automatic present(logic [3:0] op, int rd, int rs1, int rs2, logic [D-1:0] imm);
      in_valid = 1'b1; in_op = op;
      in_rd = RAW'(rd); in_rs1 = RAW'(rs1); in_rs2 = RAW'(rs2); in_imm = imm;
   endtask

   task automatic send(logic [3:0] op, int rd, int rs1, int rs2, logic [D-1:0] imm, output int cyc);
      logic rdy;
      @(negedge clk);
      present(op, rd, rs1, rs2, imm);
      cyc = 0;
      forever begin
         #1 rdy = in_ready;
         @(posedge clk);
         cyc++;
         if (rdy) break;
         @(negedge clk);
      end
      #1 in_valid = 1'b0;
      in_op = '0;
   endtask

   task automatic sv_read(int s, int i);
      sv_slot = SAW'(s); sv_idx = OAW'(i);
      #1;
   endtask

   task automatic sv_write(int s, int i, logic v, logic [EW-1:0] e);
      @(negedge clk);
      sv_slot = SAW'(s); sv_idx = OAW'(i); sv_wvalid = v; sv_wentry = e; sv_we = 1'b1;
      @(posedge clk);
      #1 sv_we = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      int c;
      logic [D-1:0] a, b;
      rst_n = 1'b0; in_valid = 1'b0; in_op = '0; in_rd = '0; in_rs1 = '0; in_rs2 = '0;
      in_imm = '0; reg_busy = '0; sv_slot = '0; sv_idx = '0; sv_we = 1'b0;
      sv_wvalid = 1'b0; sv_wentry = '0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      #1;

      // R1: reset state
      for (int r = 0; r < NR; r++) check("R1", "reg after reset", rv(r), 0);
      check("R1", "defining", defining_o, 0);
      check("R1", "err_dup", err_dup_o, 0);
      check("R1", "err_ovf", err_ovf_o, 0);
      check("R1", "ready", in_ready, 1);
      for (int s = 0; s < NS; s++)
         for (int i = 0; i < NO; i++) begin
            sv_read(s, i);
            check("R1", "slot entry valid", sv_rvalid, 0);
         end

      // R2: ALU sweep
      for (int i = 0; i < 16; i++)
         for (int j = 0; j < 16; j++) begin
            a = D'(i * 17 + 1);
            b = D'(j * 29);
            send(OP_MOVI, 1, 0, 0, a, c);
            send(OP_MOVI, 2, 0, 0, b, c);
            send(OP_ADD, 0, 1, 2, 0, c);
            check("R2", "ADD", rv(0), D'(a + b));
            send(OP_SUB, 3, 1, 2, 0, c);
            check("R2", "SUB", rv(3), D'(a - b));
            send(OP_AND, 0, 1, 2, 0, c);
            check("R2", "AND", rv(0), a & b);
            send(OP_XOR, 0, 1, 2, 0, c);
            check("R2", "XOR", rv(0), a ^ b);
         end
      send(OP_NOP, 0, 1, 2, 8'h77, c);
      check("R2", "NOP leaves reg", rv(0), a ^ b);

      // R3 / R5: define and call
      send(OP_MOVI, 0, 0, 0, 10, c);
      send(OP_MOVI, 1, 0, 0, 3, c);
      send(OP_MOVI, 2, 0, 0, 0, c);
      send(OP_MOVI, 3, 0, 0, 0, c);
      send(OP_BEGIN, 0, 0, 0, 0, c);
      check("R3", "defining after BEGIN", defining_o, 1);
      reg_busy = 4'hF;
      send(OP_ADD, 0, 0, 1, 0, c);
      check("R3", "record does not stall", c, 1);
      reg_busy = '0;
      send(OP_XOR, 1, 0, 3, 0, c);
      send(OP_SUB, 2, 0, 1, 0, c);
      send(OP_MOVI, 3, 0, 0, 8'h55, c);
      check("R3", "r0 not executed", rv(0), 10);
      check("R3", "r3 not executed", rv(3), 0);
      sv_read(0, 3);
      check("R10", "read valid", sv_rvalid, 1);
      check("R10", "read entry", sv_rentry, ent(OP_MOVI, 3, 0, 0, 8'h55));
      send(OP_END, 0, 0, 0, 0, c);
      check("R3", "defining after END", defining_o, 0);
      send(OP_CALL, 0, 0, 0, 0, c);
      check("R5", "call cycles", c, 1);
      check("R5", "r0", rv(0), 13);
      check("R5", "r1 old r0", rv(1), 10);
      check("R5", "r2 old values", rv(2), 7);
      check("R5", "r3", rv(3), 8'h55);
      check("R6", "no dup", err_dup_o, 0);
      send(OP_CALL, 0, 0, 0, 0, c);
      check("R5", "r0 second", rv(0), 23);
      check("R5", "r1 second", rv(1), 8'h58);
      check("R5", "r2 second", rv(2), 3);

      // R4 / R6: overflow and duplicate writers
      send(OP_BEGIN, 0, 0, 0, 1, c);
      send(OP_MOVI, 2, 0, 0, 1, c);
      send(OP_MOVI, 2, 0, 0, 2, c);
      send(OP_NOP, 0, 0, 0, 0, c);
      send(OP_NOP, 0, 0, 0, 0, c);
      check("R4", "no ovf at capacity", err_ovf_o, 0);
      send(OP_MOVI, 3, 0, 0, 9, c);
      check("R4", "ovf flag", err_ovf_o, 1);
      send(OP_END, 0, 0, 0, 0, c);
      send(OP_CALL, 0, 0, 0, 1, c);
      check("R6", "dup flag", err_dup_o, 1);
      check("R6", "higher entry wins", rv(2), 2);
      check("R4", "discarded entry", rv(3), 8'h55);

      // R8: clear
      send(OP_CLEAR, 0, 0, 0, 1, c);
      for (int i = 0; i < NO; i++) begin
         sv_read(1, i);
         check("R8", "cleared valid", sv_rvalid, 0);
      end
      send(OP_MOVI, 2, 0, 0, 8'h66, c);
      send(OP_CALL, 0, 0, 0, 1, c);
      check("R8", "empty call", rv(2), 8'h66);
      check("R8", "empty call no dup", err_dup_o, 0);

      // R7: loop over macro
      send(OP_BEGIN, 0, 0, 0, 1, c);
      send(OP_ADD, 2, 2, 1, 0, c);
      send(OP_END, 0, 0, 0, 0, c);
      send(OP_MOVI, 0, 0, 0, 0, c);
      send(OP_MOVI, 1, 0, 0, 2, c);
      send(OP_MOVI, 2, 0, 0, 0, c);
      send(OP_MOVI, 3, 0, 0, 5, c);
      send(OP_LOOP, 0, 3, 0, 1, c);
      check("R7", "iterations", c, 5);
      check("R7", "counter", rv(0), 5);
      check("R7", "accumulated", rv(2), 10);
      send(OP_MOVI, 0, 0, 0, 7, c);
      send(OP_LOOP, 0, 3, 0, 1, c);
      check("R7", "past limit iterations", c, 1);
      check("R7", "past limit counter", rv(0), 8);
      check("R7", "past limit body", rv(2), 12);
      send(OP_MOVI, 0, 0, 0, 8'hFF, c);
      send(OP_MOVI, 3, 0, 0, 8'hFF, c);
      send(OP_LOOP, 0, 3, 0, 1, c);
      check("R7", "no wrap compare", c, 1);
      check("R7", "wrapped counter", rv(0), 0);
      send(OP_MOVI, 0, 0, 0, 8, c);
      send(OP_MOVI, 3, 0, 0, 5, c);
      send(OP_LOOP, 1, 1, 0, 0, c);
      check("R6", "loop dup flag", err_dup_o, 1);
      check("R6", "counter wins", rv(1), 3);
      check("R5", "loop body r0", rv(0), 10);
      check("R5", "loop body r2", rv(2), 6);

      // R9: operand stall
      reg_busy = 4'b0010;
      @(negedge clk);
      present(OP_ADD, 0, 1, 2, 0);
      #1 check("R9", "ready low", in_ready, 0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      #1 check("R9", "reg held", rv(0), 10);
      check("R9", "still low", in_ready, 0);
      reg_busy = '0;
      #1 check("R9", "ready after release", in_ready, 1);
      @(posedge clk);
      #1 in_valid = 1'b0;
      check("R9", "executes after release", rv(0), 9);
      reg_busy = 4'b1000;
      send(OP_SUB, 0, 1, 2, 0, c);
      check("R9", "unrelated busy", c, 1);
      check("R9", "unrelated result", rv(0), 8'hFD);
      reg_busy = 4'b0010;
      @(negedge clk);
      present(OP_CALL, 0, 0, 0, 0);
      #1 check("R9", "macro source busy", in_ready, 0);
      @(negedge clk);
      in_valid = 1'b0;
      reg_busy = '0;
      #1 check("R9", "macro stall held", rv(0), 8'hFD);

      // R10: restore a slot
      sv_write(0, 0, 1'b1, ent(OP_MOVI, 3, 0, 0, 8'h2A));
      for (int i = 1; i < NO; i++) sv_write(0, i, 1'b0, '0);
      sv_read(0, 0);
      check("R10", "restored entry", sv_rentry, ent(OP_MOVI, 3, 0, 0, 8'h2A));
      send(OP_CALL, 0, 0, 0, 0, c);
      check("R10", "restored executes", rv(3), 8'h2A);
      check("R10", "invalidated entries", rv(0), 8'hFD);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule